// File: doc/BRIEF.md
# Receive Carrier-Sense Idle Timer

This block derives a carrier-sense level for a serial receiver from activity on its data line. Any edge on the received data raises carrier sense, which then stays high until the line has been quiet for a programmable number of sample clocks. Once that quiet interval has passed, carrier sense falls, which signals to the surrounding receiver logic that the line is free. A one-clock change pulse marks every rise and every fall of the level.

The quiet interval is picked with a 2-bit code. Its length depends on the sampling mode. In 1x mode each clock is one bit time, and the interval takes the larger value of a fixed pair. In the 8x, 16x and 32x oversampled modes the interval takes the smaller, fractional value of the pair, scaled by the oversampling ratio into clocks. Code zero turns the timer off, and carrier sense then stays high for good. A change of code or mode restarts the quiet count, so no timeout can ever mix two settings.

Top module: `rx_carrier_sense`

## Requirements
- R1: After reset `crs` is 1 and `crs_chg` is 0. While `gap_code` is 00, `crs` is 1 one clock later and stays 1 no matter how quiet the line is. If `crs` was 0 when 00 is applied, it rises at the next clock edge.
- R2: Code 01 sets the quiet interval to 14 clocks in 1x mode and to 6.5 x N clocks in oversampled mode.
- R3: Code 10 sets the quiet interval to 4 clocks in 1x mode and to 1.5 x N clocks in oversampled mode.
- R4: Code 11 sets the quiet interval to 3 clocks in 1x mode and to N clocks in oversampled mode.
- R5: Suppose the last change of `rxd` is sampled at clock edge k, and the interval is L clocks. Then `crs` is 1 after edge k and falls after edge k+L. If another change is sampled at any edge up to and including k+L, `crs` does not fall, and the count starts again from that change.
- R6: `os_sel` selects the mode and N as follows: 00 = 1x, 01 = 8x, 10 = 16x, 11 = 32x.
- R7: `crs_chg` is 1 for exactly the one clock in which `crs` first shows a new level, and it is 0 at all other times.
- R8: A change of `os_sel` or `gap_code` that is sampled at edge k restarts the quiet count. If `crs` is 1 and the new code is not 00, `crs` falls after edge k+L, where L is the new interval. A count that was partly done under the old setting does not carry over. If `crs` is 0, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (bit clock in 1x mode, oversampling clock otherwise) |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Received serial data line |
| os_sel | input | 2 | Sampling mode: 00 1x, 01 8x, 10 16x, 11 32x |
| gap_code | input | 2 | Quiet-interval code, 00 = never release |
| crs | output | 1 | Carrier-sense level |
| crs_chg | output | 1 | One-clock pulse on each change of `crs` |

## Verification
The checker verifies four rules on every cycle. Code 00 forces carrier sense high. Any change of `rxd` raises carrier sense by the next clock. Carrier sense never falls right after a line edge or under code 00. The change pulse lines up with real level changes. Only the bench scenarios can show the exact interval for each of the twelve code and mode pairs. The bench scenarios also cover the off-by-one boundary, where an edge arrives in the same cycle that a timeout would fire, and the restart of the count when the configuration changes partway through an interval.

// File: rtl/rx_carrier_sense.sv
module rx_carrier_sense #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic [1:0] os_sel,
  input  logic [1:0] gap_code,
  output logic       crs,
  output logic       crs_chg
);
  localparam int         W       = CNT_W + 4;
  localparam logic [1:0] GAP_INF = 2'b00;

  logic             rxd_q, crs_d;
  logic [3:0]       cfg_q;
  logic [CNT_W-1:0] cnt, limit;
  logic [W-1:0]     n_os, lim_w;
  logic             line_edge, cfg_chg;

  assign line_edge = rxd ^ rxd_q;
  assign cfg_chg   = cfg_q != {os_sel, gap_code};
  assign crs_chg   = crs ^ crs_d;
  assign limit     = lim_w[CNT_W-1:0];

  always_comb begin
    unique case (os_sel)
      2'b01:   n_os = W'(8);
      2'b10:   n_os = W'(16);
      2'b11:   n_os = W'(32);
      default: n_os = W'(1);
    endcase
    if (os_sel == 2'b00) begin
      unique case (gap_code)
        2'b01:   lim_w = W'(14);
        2'b10:   lim_w = W'(4);
        default: lim_w = W'(3);
      endcase
    end else begin
      unique case (gap_code)
        2'b01:   lim_w = (n_os * W'(13)) >> 1;
        2'b10:   lim_w = (n_os * W'(3)) >> 1;
        default: lim_w = n_os;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q <= 1'b1;
      crs   <= 1'b1;
      crs_d <= 1'b1;
      cnt   <= '0;
      cfg_q <= '0;
    end else begin
      rxd_q <= rxd;
      crs_d <= crs;
      cfg_q <= {os_sel, gap_code};
      if (line_edge || gap_code == GAP_INF) begin
        crs <= 1'b1;
        cnt <= '0;
      end else if (cfg_chg) begin
        cnt <= '0;
      end else if (crs) begin
        if (cnt == limit - 1'b1) begin
          crs <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_carrier_sense_chk.sv
module rx_carrier_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxd,
  input logic [1:0] gap_code,
  input logic       crs,
  input logic       crs_chg
);
  p_inf_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_code == 2'b00) |=> crs);

  p_edge_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rxd) |=> crs);

  p_fall_needs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs) |-> ($past(rxd) == $past(rxd, 2)) && ($past(gap_code) != 2'b00));

  p_chg_on_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(crs) || $fell(crs)) |-> crs_chg);

  p_chg_only_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crs_chg |-> !$stable(crs));
endmodule

bind rx_carrier_sense rx_carrier_sense_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rxd(rxd), .gap_code(gap_code),
  .crs(crs), .crs_chg(crs_chg)
);

// File: tb/test_rx_carrier_sense.sv
module test_rx_carrier_sense;
  typedef struct {
    int    at;
    bit    lvl;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] os_sel = 2'b00;
  logic [1:0] gap_code = 2'b00;
  logic       crs, crs_chg;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  crs_exp = 1'b1;
  bit  done = 1'b0;
  ev_t q[$];

  rx_carrier_sense i_rx_carrier_sense (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_sel(os_sel),
    .gap_code(gap_code), .crs(crs), .crs_chg(crs_chg)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int interval(input logic [1:0] os, input logic [1:0] code);
    int n;
    n = (os == 2'b01) ? 8 : (os == 2'b10) ? 16 : 32;
    if (os == 2'b00) return (code == 2'b01) ? 14 : (code == 2'b10) ? 4 : 3;
    return (code == 2'b01) ? (n * 13) / 2 : (code == 2'b10) ? (n * 3) / 2 : n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic toggle(input int w, input string req);
    int c, l;
    @(negedge clk);
    c = cyc;
    rxd = ~rxd;
    if (!crs_exp) q.push_back('{c + 1, 1'b1, req});
    crs_exp = 1'b1;
    if (gap_code != 2'b00) begin
      l = interval(os_sel, gap_code);
      if (w > l) begin
        q.push_back('{c + 1 + l, 1'b0, req});
        crs_exp = 1'b0;
      end
    end
    repeat (w - 1) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] os, input logic [1:0] code, input int w,
                         input string req);
    int c, l;
    @(negedge clk);
    c = cyc;
    os_sel = os;
    gap_code = code;
    if (code == 2'b00) begin
      if (!crs_exp) q.push_back('{c + 1, 1'b1, req});
      crs_exp = 1'b1;
    end else if (crs_exp) begin
      l = interval(os, code);
      if (w > l) begin
        q.push_back('{c + 1 + l, 1'b0, req});
        crs_exp = 1'b0;
      end
    end
    repeat (w - 1) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].at < cyc) begin
        check({q[0].req, " missed change"}, cyc, q[0].at);
        void'(q.pop_front());
      end
      if (crs_chg) begin
        if (q.size() == 0) begin
          check("R7 unexpected change", 1, 0);
        end else begin
          check({q[0].req, " change cycle"}, cyc, q[0].at);
          check({q[0].req, " level"}, int'(crs), int'(q[0].lvl));
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset crs", int'(crs), 1);
    check("R1 reset crs_chg", int'(crs_chg), 0);

    set_cfg(2'b00, 2'b00, 60, "R1");
    check("R1 infinite crs", int'(crs), 1);

    set_cfg(2'b00, 2'b01, 20, "R2");
    toggle(20, "R2 1x");
    set_cfg(2'b00, 2'b10, 10, "R3");
    toggle(4, "R3 boundary");
    toggle(5, "R3 1x");
    set_cfg(2'b00, 2'b11, 6, "R4");
    toggle(3, "R4 boundary");
    toggle(4, "R4 1x");
    for (int i = 0; i < 6; i++) toggle(1, "R5 burst");
    toggle(10, "R5 after burst");

    set_cfg(2'b10, 2'b01, 5, "R6");
    toggle(104, "R2 16x boundary");
    toggle(105, "R2 16x");
    set_cfg(2'b01, 2'b01, 3, "R6");
    toggle(60, "R2 8x");
    set_cfg(2'b11, 2'b01, 3, "R6");
    toggle(220, "R2 32x");
    set_cfg(2'b01, 2'b10, 3, "R6");
    toggle(20, "R3 8x");
    set_cfg(2'b10, 2'b10, 3, "R6");
    toggle(24, "R3 16x boundary");
    toggle(30, "R3 16x");
    set_cfg(2'b11, 2'b10, 3, "R6");
    toggle(60, "R3 32x");
    set_cfg(2'b01, 2'b11, 3, "R6");
    toggle(10, "R4 8x");
    set_cfg(2'b11, 2'b11, 3, "R6");
    toggle(40, "R4 32x");

    set_cfg(2'b01, 2'b11, 3, "R8");
    toggle(6, "R8 partial");
    set_cfg(2'b11, 2'b11, 40, "R8 restart");
    set_cfg(2'b00, 2'b01, 3, "R8");
    toggle(10, "R8 partial");
    set_cfg(2'b00, 2'b10, 8, "R8 restart");
    set_cfg(2'b00, 2'b11, 10, "R8 stays low");
    check("R8 crs stays low", int'(crs), 0);

    set_cfg(2'b00, 2'b00, 30, "R1 release");
    check("R1 crs forced", int'(crs), 1);
    toggle(30, "R1 no timeout");

    repeat (5) @(negedge clk);
    check("R7 pending changes", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule